// File: doc/BRIEF.md
# Flash Block Erase-Verify Sequencer

This block runs the erase procedure of an embedded flash array without software in the loop. After a start pulse it takes a mask of blocks and handles them one at a time, lowest index first. For each block it steps the array's control strobes through a fixed nested order: write enable, watchdog arm, erase setup, erase pulse, and then the releases in reverse. A timed wait follows every edge. It then enters verify mode and reads the block back word by word, expecting all ones. A block that fails verify is erased again until a retry limit is reached. At that point the run stops with a failure, and the failing block and word address stay available for inspection.

Every wait is a cycle count taken from an input. The erase pulse has a wider input of its own, because it is far longer than the other waits. The control is one state machine with these states: IDLE, SWE_SET, NEXT, WDT_ON, ESU_SET, PULSE, E_CLR, ESU_CLR, WDT_OFF, EV_SET, DUMMY, EV_WAIT, READ, EV_OK, EV_BAD and SWE_CLR.

The transitions run as follows:
- IDLE goes to SWE_SET on a start with a non-empty mask.
- SWE_SET goes to NEXT.
- NEXT goes to WDT_ON when a pending block exists, and to SWE_CLR when none is left.
- The erase chain runs WDT_ON, ESU_SET, PULSE, E_CLR, ESU_CLR, WDT_OFF, EV_SET, DUMMY.
- DUMMY goes to EV_WAIT, and EV_WAIT goes to READ.
- READ goes back to DUMMY for the next word. It goes to EV_OK after the last word, and to EV_BAD on a mismatch.
- EV_OK goes to NEXT.
- EV_BAD goes to WDT_ON for a retry, or to SWE_CLR when the limit is reached.
- SWE_CLR goes to IDLE.

Top module: `flash_erase_seq`

## Requirements
- R1: Write enable rises one clock edge after a start is accepted and stays high for the setup count plus one cycles before the first block begins. It falls in the last phase (after the last block, or on failure) and stays low for the hold count plus one cycles before done or fail. Busy is high from the accepted start until that phase ends. Write enable stays low otherwise.
- R2: Block select is one-hot and is driven only from the watchdog-arm step to the end of that block's verify. Masked blocks are served from bit 0 upward, one after another.
- R3: Each erase attempt sets watchdog, sets setup, sets pulse, clears pulse, clears setup, clears watchdog, in that order. Each step lasts its wait count plus one cycles. The watchdog-arm wait is also used after disarm.
- R4: The erase pulse length comes from its own wider count input and lasts that count plus one cycles. No program operation precedes it.
- R5: The verify bit rises and holds for its setup count plus one cycles. Then, for each word starting at address block*BLK_WORDS and rising, the block does the following: a one-cycle write of 0x00FF to that word, a wait of the read count plus one cycles, and a one-cycle read of the same address. Writes and reads occur only while the verify bit is high.
- R6: A word equal to 0xFFFF passes. The first word that differs ends the read-back at once. A block passes only if all BLK_WORDS words pass. After the block passes or fails, the verify bit is cleared and a clear wait follows.
- R7: The attempt count starts at 1 for each block. After a failed verify, if the count is at or above the limit, the run fails; otherwise the count increases and the block is erased again. A limit of 0 acts as 1.
- R8: On failure, the failing block index and the word address of the mismatch read in the final attempt are held until the next accepted start. Blocks above the failing one are not touched.
- R9: Done (success) or fail (failure) is a one-cycle pulse in the first idle cycle after the hold phase. The two are never high together.
- R10: A start with an all-zero mask gives a done pulse at the next clock edge and moves no control strobe.
- R11: A start while busy is ignored.
- R12: In reset, every strobe, select and flag output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| blk_mask_i | input | NBLK | Blocks to erase |
| t_swe_on_i | input | US_W | Wait after write enable rises |
| t_swe_off_i | input | US_W | Wait after write enable falls |
| t_wdt_i | input | US_W | Wait after watchdog arm and disarm |
| t_esu_on_i | input | US_W | Wait after erase setup rises |
| t_pulse_i | input | PLS_W | Erase pulse length |
| t_pulse_off_i | input | US_W | Wait after pulse falls |
| t_esu_off_i | input | US_W | Wait after erase setup falls |
| t_ver_on_i | input | US_W | Wait after verify bit rises |
| t_ver_rd_i | input | US_W | Wait between dummy write and read |
| t_ver_off_i | input | US_W | Wait after verify bit falls |
| max_try_i | input | TRY_W | Erase attempt limit per block |
| fl_swe_o | output | 1 | Software write enable |
| fl_esu_o | output | 1 | Erase setup |
| fl_e_o | output | 1 | Erase pulse |
| fl_ev_o | output | 1 | Erase-verify mode |
| fl_blk_o | output | NBLK | One-hot block select |
| wdt_en_o | output | 1 | Watchdog arm |
| fl_addr_o | output | AW | Word address |
| fl_wr_o | output | 1 | Dummy write strobe |
| fl_wdata_o | output | 16 | Write data |
| fl_rd_o | output | 1 | Read strobe |
| fl_rdata_i | input | 16 | Read data, valid in the cycle of the read strobe |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Success pulse |
| fail_o | output | 1 | Failure pulse |
| fail_blk_o | output | IW | Failing block index |
| fail_addr_o | output | AW | Mismatching word address |

## Verification
The assertions assume that the wait counts and the attempt limit do not change while busy is high. They also assume that the read data is a combinational function of the address during a read. The attempt-bound check depends on the first of these. The bench sets every timing and limit input between runs only, while the block is idle. It changes the mask and pulses start in the middle of a run only to show that both are ignored. Its array model answers reads at once from the current address, and it erases a block only on the falling edge of the pulse for the selected block.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SWE_SET,
        S_NEXT,
        S_WDT_ON,
        S_ESU_SET,
        S_PULSE,
        S_E_CLR,
        S_ESU_CLR,
        S_WDT_OFF,
        S_EV_SET,
        S_DUMMY,
        S_EV_WAIT,
        S_READ,
        S_EV_OK,
        S_EV_BAD,
        S_SWE_CLR
    } fes_state_e;

    localparam logic [15:0] ERASED_WORD = 16'hFFFF;
    localparam logic [15:0] DUMMY_WORD  = 16'h00FF;

endpackage

// File: rtl/fes_wait_timer.sv
module fes_wait_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/fes_blk_pick.sv
module fes_blk_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  pend_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int BLK_WORDS = 16,
    parameter int US_W      = 16,
    parameter int PLS_W     = 24,
    parameter int TRY_W     = 4,
    localparam int IW       = $clog2(NBLK),
    localparam int WOW      = $clog2(BLK_WORDS),
    localparam int AW       = IW + WOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NBLK-1:0]  blk_mask_i,
    input  logic [US_W-1:0]  t_swe_on_i,
    input  logic [US_W-1:0]  t_swe_off_i,
    input  logic [US_W-1:0]  t_wdt_i,
    input  logic [US_W-1:0]  t_esu_on_i,
    input  logic [PLS_W-1:0] t_pulse_i,
    input  logic [US_W-1:0]  t_pulse_off_i,
    input  logic [US_W-1:0]  t_esu_off_i,
    input  logic [US_W-1:0]  t_ver_on_i,
    input  logic [US_W-1:0]  t_ver_rd_i,
    input  logic [US_W-1:0]  t_ver_off_i,
    input  logic [TRY_W-1:0] max_try_i,
    output logic             fl_swe_o,
    output logic             fl_esu_o,
    output logic             fl_e_o,
    output logic             fl_ev_o,
    output logic [NBLK-1:0]  fl_blk_o,
    output logic             wdt_en_o,
    output logic [AW-1:0]    fl_addr_o,
    output logic             fl_wr_o,
    output logic [15:0]      fl_wdata_o,
    output logic             fl_rd_o,
    input  logic [15:0]      fl_rdata_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o,
    output logic [IW-1:0]    fail_blk_o,
    output logic [AW-1:0]    fail_addr_o
);

    localparam logic [WOW-1:0] LAST_OFF = WOW'(BLK_WORDS - 1);

    fes_state_e        state_q, nxt;
    logic [NBLK-1:0]   pend_q;
    logic [IW-1:0]     blk_q, pick_idx;
    logic [WOW-1:0]    woff_q;
    logic [TRY_W-1:0]  try_q, eff_max;
    logic              err_q, done_q, fail_q, pick_found, tz;
    logic [IW-1:0]     fblk_q;
    logic [AW-1:0]     faddr_q;
    logic [PLS_W-1:0]  wait_val;
    logic              word_bad, at_limit;

    fes_wait_timer #(.W(PLS_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (nxt != state_q),
        .val_i  (wait_val),
        .zero_o (tz)
    );

    fes_blk_pick #(.N(NBLK), .IW(IW)) u_pick (
        .pend_i  (pend_q),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    assign eff_max  = (max_try_i == '0) ? TRY_W'(1) : max_try_i;
    assign at_limit = (try_q >= eff_max);
    assign word_bad = (fl_rdata_i != ERASED_WORD);

    // next state
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            S_IDLE:    if (start_i && blk_mask_i != '0) nxt = S_SWE_SET;
            S_SWE_SET: if (tz) nxt = S_NEXT;
            S_NEXT:    nxt = pick_found ? S_WDT_ON : S_SWE_CLR;
            S_WDT_ON:  if (tz) nxt = S_ESU_SET;
            S_ESU_SET: if (tz) nxt = S_PULSE;
            S_PULSE:   if (tz) nxt = S_E_CLR;
            S_E_CLR:   if (tz) nxt = S_ESU_CLR;
            S_ESU_CLR: if (tz) nxt = S_WDT_OFF;
            S_WDT_OFF: if (tz) nxt = S_EV_SET;
            S_EV_SET:  if (tz) nxt = S_DUMMY;
            S_DUMMY:   nxt = S_EV_WAIT;
            S_EV_WAIT: if (tz) nxt = S_READ;
            S_READ: begin
                if (word_bad)                nxt = S_EV_BAD;
                else if (woff_q == LAST_OFF) nxt = S_EV_OK;
                else                         nxt = S_DUMMY;
            end
            S_EV_OK:   if (tz) nxt = S_NEXT;
            S_EV_BAD:  if (tz) nxt = at_limit ? S_SWE_CLR : S_WDT_ON;
            S_SWE_CLR: if (tz) nxt = S_IDLE;
        endcase
    end

    // wait count loaded on entry to the next state
    always_comb begin
        unique case (nxt)
            S_SWE_SET:           wait_val = PLS_W'(t_swe_on_i);
            S_WDT_ON, S_WDT_OFF: wait_val = PLS_W'(t_wdt_i);
            S_ESU_SET:           wait_val = PLS_W'(t_esu_on_i);
            S_PULSE:             wait_val = t_pulse_i;
            S_E_CLR:             wait_val = PLS_W'(t_pulse_off_i);
            S_ESU_CLR:           wait_val = PLS_W'(t_esu_off_i);
            S_EV_SET:            wait_val = PLS_W'(t_ver_on_i);
            S_EV_WAIT:           wait_val = PLS_W'(t_ver_rd_i);
            S_EV_OK, S_EV_BAD:   wait_val = PLS_W'(t_ver_off_i);
            S_SWE_CLR:           wait_val = PLS_W'(t_swe_off_i);
            default:             wait_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            blk_q   <= '0;
            woff_q  <= '0;
            try_q   <= '0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
            fblk_q  <= '0;
            faddr_q <= '0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    pend_q  <= blk_mask_i;
                    err_q   <= 1'b0;
                    fblk_q  <= '0;
                    faddr_q <= '0;
                    if (blk_mask_i == '0) done_q <= 1'b1;
                end
                S_NEXT: if (pick_found) begin
                    blk_q <= pick_idx;
                    try_q <= TRY_W'(1);
                end
                S_EV_SET: woff_q <= '0;
                S_READ: begin
                    if (word_bad) begin
                        if (at_limit) begin
                            fblk_q  <= blk_q;
                            faddr_q <= fl_addr_o;
                        end
                    end else if (woff_q != LAST_OFF) begin
                        woff_q <= woff_q + 1'b1;
                    end
                end
                S_EV_OK: if (tz) pend_q[blk_q] <= 1'b0;
                S_EV_BAD: if (tz) begin
                    if (at_limit) err_q <= 1'b1;
                    else          try_q <= try_q + 1'b1;
                end
                S_SWE_CLR: if (tz) begin
                    done_q <= ~err_q;
                    fail_q <= err_q;
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        fl_swe_o = 1'b0;
        fl_esu_o = 1'b0;
        fl_e_o   = 1'b0;
        fl_ev_o  = 1'b0;
        wdt_en_o = 1'b0;
        fl_wr_o  = 1'b0;
        fl_rd_o  = 1'b0;
        fl_blk_o = '0;
        unique case (state_q)
            S_IDLE, S_SWE_CLR: ;
            S_SWE_SET, S_NEXT: fl_swe_o = 1'b1;
            S_WDT_ON, S_WDT_OFF, S_EV_OK, S_EV_BAD: begin
                fl_swe_o = 1'b1;
                fl_blk_o = NBLK'(1) << blk_q;
                wdt_en_o = (state_q == S_WDT_ON);
            end
            S_ESU_SET, S_PULSE, S_E_CLR, S_ESU_CLR: begin
                fl_swe_o = 1'b1;
                fl_blk_o = NBLK'(1) << blk_q;
                wdt_en_o = 1'b1;
                fl_esu_o = (state_q != S_ESU_CLR);
                fl_e_o   = (state_q == S_PULSE);
            end
            S_EV_SET, S_DUMMY, S_EV_WAIT, S_READ: begin
                fl_swe_o = 1'b1;
                fl_blk_o = NBLK'(1) << blk_q;
                fl_ev_o  = 1'b1;
                fl_wr_o  = (state_q == S_DUMMY);
                fl_rd_o  = (state_q == S_READ);
            end
        endcase
    end

    assign fl_addr_o   = {blk_q, woff_q};
    assign fl_wdata_o  = DUMMY_WORD;
    assign busy_o      = (state_q != S_IDLE);
    assign done_o      = done_q;
    assign fail_o      = fail_q;
    assign fail_blk_o  = fblk_q;
    assign fail_addr_o = faddr_q;

    // assertions
    p_blk_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fl_blk_o));

    p_pulse_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_e_o |-> (fl_esu_o && wdt_en_o && fl_swe_o && fl_blk_o != '0));

    p_pulse_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_e_o) |-> $past(fl_esu_o));

    p_verify_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ev_o |-> (!fl_esu_o && !wdt_en_o && !fl_e_o));

    p_access_in_verify_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr_o || fl_rd_o) |-> fl_ev_o);

    p_try_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_blk_o != '0) |-> (try_q >= TRY_W'(1) && try_q <= eff_max));

    p_swe_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_swe_o) |-> (fl_blk_o == '0 && !fl_ev_o && !wdt_en_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> (!done_o && !fail_o));

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));

endmodule

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

    localparam int NBLK = 4;
    localparam int BW   = 16;
    localparam int AW   = 6;
    localparam int VW   = 7 + NBLK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic            start_i = 1'b0;
    logic [NBLK-1:0] mask_i = '0;
    logic [15:0] t_swe_on = 0, t_swe_off = 0, t_wdt = 0, t_esu_on = 0;
    logic [23:0] t_pulse = 0;
    logic [15:0] t_pulse_off = 0, t_esu_off = 0, t_ver_on = 0, t_ver_rd = 0, t_ver_off = 0;
    logic [3:0]  max_try = 4'd1;

    logic fl_swe, fl_esu, fl_e, fl_ev, wdt_en, fl_wr, fl_rd, busy, done, fail;
    logic [NBLK-1:0] fl_blk;
    logic [AW-1:0]   fl_addr, fail_addr;
    logic [15:0]     fl_wdata, fl_rdata;
    logic [1:0]      fail_blk;

    flash_erase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .blk_mask_i(mask_i),
        .t_swe_on_i(t_swe_on), .t_swe_off_i(t_swe_off), .t_wdt_i(t_wdt),
        .t_esu_on_i(t_esu_on), .t_pulse_i(t_pulse), .t_pulse_off_i(t_pulse_off),
        .t_esu_off_i(t_esu_off), .t_ver_on_i(t_ver_on), .t_ver_rd_i(t_ver_rd),
        .t_ver_off_i(t_ver_off), .max_try_i(max_try),
        .fl_swe_o(fl_swe), .fl_esu_o(fl_esu), .fl_e_o(fl_e), .fl_ev_o(fl_ev),
        .fl_blk_o(fl_blk), .wdt_en_o(wdt_en), .fl_addr_o(fl_addr), .fl_wr_o(fl_wr),
        .fl_wdata_o(fl_wdata), .fl_rd_o(fl_rd), .fl_rdata_i(fl_rdata),
        .busy_o(busy), .done_o(done), .fail_o(fail),
        .fail_blk_o(fail_blk), .fail_addr_o(fail_addr)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural array: a block reads all ones once it has had need_init pulses
    int  need [NBLK];
    int  need_init [NBLK];
    int  bad [NBLK];
    bit  ld_model = 1'b0;
    logic e_prev = 1'b0;

    always @(negedge clk) begin
        if (ld_model) begin
            for (int b = 0; b < NBLK; b++) need[b] = need_init[b];
        end else if (e_prev && !fl_e) begin
            for (int b = 0; b < NBLK; b++)
                if (fl_blk[b] && need[b] > 0) need[b] = need[b] - 1;
        end
        e_prev = fl_e;
    end

    always_comb begin
        int ab, ao;
        ab = int'(fl_addr) / BW;
        ao = int'(fl_addr) % BW;
        fl_rdata = (need[ab] > 0 && ao == bad[ab]) ? 16'h1234 : 16'hFFFF;
    end

    // scoreboard: expected control-vector changes and verify addresses
    typedef struct { logic [VW-1:0] v; int gap; } ev_t;
    ev_t ev_q [$];
    int  addr_q [$];

    function automatic logic [VW-1:0] mkv(bit f, bit d, bit s, int b, bit w,
                                          bit es, bit e, bit ev);
        logic [NBLK-1:0] bs;
        bs = (b < 0) ? '0 : NBLK'(1) << b;
        return {f, d, s, bs, w, es, e, ev};
    endfunction

    task automatic push(input logic [VW-1:0] v, input int gap);
        ev_t x;
        x.v = v;
        x.gap = gap;
        ev_q.push_back(x);
    endtask

    logic [VW-1:0] prev_v = '0;
    int ncyc = 0;
    int last_chg = 0;

    always @(negedge clk) begin
        logic [VW-1:0] cur;
        ev_t x;
        if (rst_n) begin
            cur = {fail, done, fl_swe, fl_blk, wdt_en, fl_esu, fl_e, fl_ev};
            if (cur != prev_v) begin
                if (ev_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected control change", int'(cur), -1);
                end else begin
                    x = ev_q.pop_front();
                    chk(cur == x.v, "R3", "control vector", int'(cur), int'(x.v));
                    if (x.gap >= 0)
                        chk(ncyc - last_chg == x.gap, "R3", "cycles between edges",
                            ncyc - last_chg, x.gap);
                end
                last_chg = ncyc;
            end
            prev_v = cur;
            if (fl_wr) begin
                chk(fl_wdata == 16'h00FF, "R5", "dummy write data", int'(fl_wdata), 255);
                chk(addr_q.size() > 0 && int'(fl_addr) == addr_q[0], "R5",
                    "dummy write address", int'(fl_addr),
                    addr_q.size() > 0 ? addr_q[0] : -1);
            end
            if (fl_rd) begin
                if (addr_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected read", int'(fl_addr), -1);
                end else begin
                    chk(int'(fl_addr) == addr_q[0], "R5", "read address",
                        int'(fl_addr), addr_q[0]);
                    void'(addr_q.pop_front());
                end
            end
        end
        ncyc++;
    end

    // driver: builds the expected trace, then runs the block
    task automatic run(input logic [NBLK-1:0] mask, input int mx, input int inj,
                       input string tag);
        bit exp_fail;
        int fb, fa, g, tr, k, lim, cnt;
        bit ok;
        exp_fail = 1'b0;
        fb = 0;
        fa = 0;
        lim = (mx == 0) ? 1 : mx;
        if (mask == '0) begin
            push(mkv(0, 1, 0, -1, 0, 0, 0, 0), -1);
            push(mkv(0, 0, 0, -1, 0, 0, 0, 0), 1);
        end else begin
            push(mkv(0, 0, 1, -1, 0, 0, 0, 0), -1);
            g = int'(t_swe_on) + 2;
            for (int b = 0; b < NBLK; b++) begin
                if (mask[b] && !exp_fail) begin
                    tr = 1;
                    forever begin
                        push(mkv(0, 0, 1, b, 1, 0, 0, 0), g);
                        push(mkv(0, 0, 1, b, 1, 1, 0, 0), int'(t_wdt) + 1);
                        push(mkv(0, 0, 1, b, 1, 1, 1, 0), int'(t_esu_on) + 1);
                        push(mkv(0, 0, 1, b, 1, 1, 0, 0), int'(t_pulse) + 1);
                        push(mkv(0, 0, 1, b, 1, 0, 0, 0), int'(t_pulse_off) + 1);
                        push(mkv(0, 0, 1, b, 0, 0, 0, 0), int'(t_esu_off) + 1);
                        push(mkv(0, 0, 1, b, 0, 0, 0, 1), int'(t_wdt) + 1);
                        ok = (tr >= need_init[b]);
                        k = ok ? BW : bad[b] + 1;
                        for (int i = 0; i < k; i++) addr_q.push_back(b * BW + i);
                        push(mkv(0, 0, 1, b, 0, 0, 0, 0),
                             int'(t_ver_on) + 1 + k * (int'(t_ver_rd) + 3));
                        if (ok) begin
                            push(mkv(0, 0, 1, -1, 0, 0, 0, 0), int'(t_ver_off) + 1);
                            g = 1;
                            break;
                        end else if (tr >= lim) begin
                            exp_fail = 1'b1;
                            fb = b;
                            fa = b * BW + bad[b];
                            push(mkv(0, 0, 0, -1, 0, 0, 0, 0), int'(t_ver_off) + 1);
                            break;
                        end else begin
                            tr++;
                            g = int'(t_ver_off) + 1;
                        end
                    end
                end
            end
            if (!exp_fail) push(mkv(0, 0, 0, -1, 0, 0, 0, 0), g);
            push(mkv(exp_fail, !exp_fail, 0, -1, 0, 0, 0, 0), int'(t_swe_off) + 1);
            push(mkv(0, 0, 0, -1, 0, 0, 0, 0), 1);
        end

        @(posedge clk) ld_model = 1'b1;
        @(posedge clk) ld_model = 1'b0;
        @(negedge clk);
        mask_i  = mask;
        max_try = 4'(mx);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mask == '0) begin
            chk(busy == 1'b0, "R10", {tag, " busy after empty start"}, int'(busy), 0);
            chk(done == 1'b1, "R10", {tag, " done next edge"}, int'(done), 1);
        end else begin
            chk(busy == 1'b1, "R1", {tag, " busy after start"}, int'(busy), 1);
        end
        cnt = 0;
        while (!(done || fail)) begin
            @(negedge clk);
            cnt++;
            if (cnt == inj) begin
                // R11: start and a new mask while busy must change nothing
                mask_i  = '1;
                start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                cnt++;
            end
            if (cnt > 20000) begin
                chk(1'b0, "R9", {tag, " run never finished"}, cnt, 0);
                break;
            end
        end
        chk(done == !exp_fail, "R9", {tag, " done flag"}, int'(done), int'(!exp_fail));
        chk(fail == exp_fail, "R7", {tag, " fail flag"}, int'(fail), int'(exp_fail));
        chk(busy == 1'b0, "R1", {tag, " busy at flag"}, int'(busy), 0);
        @(negedge clk);
        chk(!done && !fail, "R9", {tag, " flag is one cycle"}, int'(done || fail), 0);
        repeat (3) @(negedge clk);
        if (exp_fail) begin
            chk(int'(fail_blk) == fb, "R8", {tag, " failing block"}, int'(fail_blk), fb);
            chk(int'(fail_addr) == fa, "R8", {tag, " failing address"}, int'(fail_addr), fa);
        end
        chk(ev_q.size() == 0, "R2", {tag, " pending control edges"}, ev_q.size(), 0);
        chk(addr_q.size() == 0, "R6", {tag, " pending verify words"}, addr_q.size(), 0);
        ev_q.delete();
        addr_q.delete();
    endtask

    task automatic set_waits(input int a, input int b, input int c, input int d,
                             input int p, input int e, input int f, input int g,
                             input int h, input int i);
        t_swe_on = 16'(a); t_swe_off = 16'(b); t_wdt = 16'(c); t_esu_on = 16'(d);
        t_pulse = 24'(p); t_pulse_off = 16'(e); t_esu_off = 16'(f);
        t_ver_on = 16'(g); t_ver_rd = 16'(h); t_ver_off = 16'(i);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int b = 0; b < NBLK; b++) begin
            need_init[b] = 0;
            bad[b] = 0;
        end
        repeat (4) @(negedge clk);
        // R12: reset state
        chk({fl_swe, fl_esu, fl_e, fl_ev, wdt_en, fl_wr, fl_rd} == '0, "R12",
            "strobes in reset", int'({fl_swe, fl_esu, fl_e, fl_ev, wdt_en, fl_wr, fl_rd}), 0);
        chk(fl_blk == '0 && !busy && !done && !fail, "R12", "select and flags in reset",
            int'({fl_blk, busy, done, fail}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R6: two blocks, the second needs a retry
        set_waits(3, 4, 2, 3, 20, 2, 3, 2, 1, 2);
        need_init[0] = 1; bad[0] = 3;
        need_init[1] = 5; bad[1] = 0;
        need_init[2] = 2; bad[2] = 15;
        need_init[3] = 1; bad[3] = 7;
        run(4'b0101, 3, -1, "two-block");

        // R10: empty mask
        run(4'b0000, 3, -1, "empty");

        // R3: all waits zero, top block
        set_waits(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        need_init[3] = 1;
        run(4'b1000, 1, -1, "zero-wait");

        // R7 R8 R11: stuck block, later block untouched, start while busy
        set_waits(1, 2, 1, 2, 9, 1, 2, 1, 2, 1);
        need_init[1] = 0;
        need_init[2] = 99; bad[2] = 9;
        need_init[3] = 1;
        run(4'b1110, 2, 40, "stuck");
        chk(int'(fail_addr) == 2 * BW + 9, "R8", "status held after run",
            int'(fail_addr), 2 * BW + 9);

        // R7: limit of zero acts as one attempt
        need_init[1] = 3; bad[1] = 4;
        run(4'b0010, 0, -1, "limit-zero");

        // R8: status cleared by the next accepted start
        need_init[0] = 1;
        run(4'b0001, 2, -1, "clear-status");
        chk(fail_blk == '0 && fail_addr == '0, "R8", "status cleared by start",
            int'({fail_blk, fail_addr}), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule